// File: doc/BRIEF.md
# Constant-Weight Syndrome Encoder

This block forms the ciphertext of a code-based public-key scheme. It computes the syndrome of a sparse error word against a parity-check matrix in systematic form, H' = (Q | I). The error word has length N = 2^M and exactly T ones. It reaches the block as a stream of T position indices, one per handshake. The syndrome has R = M·T bits and the number of Q columns is K = N − R.

Only the dense part Q is held in an external synchronous column memory with one cycle of read latency. The block drives that memory's address and read enable. A position below K fetches column p of Q and XORs it into the syndrome register. A position at or above K lies in the identity part, so it inverts syndrome bit p − K and makes no memory read. The index path and the fold path form a two-stage pipeline, so one position is absorbed per clock. A full encryption takes T + 2 cycles after the start pulse.

The block also checks its input. An index that repeats within one run, or an index at or beyond N, sets a sticky error flag. The syndrome is still produced, and the flag marks it as untrustworthy. Mapping a message to a constant-weight word, loading the key and decryption are handled elsewhere.

Top module: `cwse_syndrome_enc`

## Requirements
- R1: After a run of T indices, `syn` equals the XOR of the columns of (Q | I) named by the accepted indices. Bit r of `syn` is row r. Bit r of a Q column word is row r of that column.
- R2: An accepted index p < K drives `col_rd_en` high with `col_addr` = p in its acceptance cycle. The column word returned on the following cycle is folded into `syn`.
- R3: An accepted index p with K ≤ p < N causes no memory read and inverts exactly syndrome bit p − K.
- R4: From the cycle after `start` until T indices have been accepted, `idx_ready` stays high. Indices presented back to back are therefore taken one per cycle with no stall.
- R5: `done` rises two clock edges after the edge that accepts the T-th index. It then holds, with `syn` stable, until the next `start`.
- R6: A `start` pulse clears `syn`, `err` and `done` and restarts the count. It overrides a fold still in flight from an earlier run. `idx_ready` is low in the `start` cycle.
- R7: An index equal to an index already accepted in the same run sets `err`. Its column is folded again anyway. `err` stays set until the next `start`.
- R8: An index ≥ N (the index port is M+1 bits wide) sets `err`, leaves `syn` untouched and counts toward the T indices.
- R9: Once T indices are accepted, `idx_ready` is low. Further `idx_valid` activity leaves `syn` unchanged.
- R10: After reset, `done`, `err`, `idx_ready`, `col_rd_en` and `syn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a new encryption |
| idx_valid | input | 1 | An error position is offered |
| idx | input | M+1 | Error position index |
| idx_ready | output | 1 | Block accepts the offered index this cycle |
| col_rd_en | output | 1 | Read strobe to the Q column memory |
| col_addr | output | M+1 | Q column address |
| col_data | input | M·T | Column word, valid one cycle after the read |
| syn | output | M·T | Syndrome accumulator / ciphertext |
| done | output | 1 | All T positions folded; syndrome final |
| err | output | 1 | Repeated or out-of-range index seen in this run |

## Verification
Two events can fall in the same cycle: a `start` pulse and the fold of a column fetched by the previous run. The bench provokes this by starting a run, feeding an out-of-range index and then a Q-region index, and raising `start` in the very cycle that the fetched column is due to land. It then checks that `syn`, `err` and `done` read zero. It also checks that the following clean run matches the bit-serial reference exactly, which shows the stale column never leaked in. Random distinct index sets and directed boundary sets cover both regions and both kinds of error, each compared against a full-matrix reference computed in the bench.

// File: rtl/cwse_pkg.sv
package cwse_pkg;

    // Phase of one encryption run.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FLUSH = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

endpackage

// File: rtl/cwse_seen_list.sv
// Remembers the indices accepted in the current run and flags a repeat.
module cwse_seen_list #(
    parameter int T  = 27,
    parameter int IW = 12,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_slot,
    input  logic [IW-1:0] q_idx,
    output logic          hit
);

    typedef struct packed {
        logic [T-1:0][IW-1:0] ent;
        logic [T-1:0]         vld;
    } list_t;

    list_t        lst_d, lst_q;
    logic [T-1:0] match;

    for (genvar g = 0; g < T; g++) begin : g_cmp
        assign match[g] = lst_q.vld[g] && (lst_q.ent[g] == q_idx);
    end

    always_comb begin
        lst_d = lst_q;
        hit   = |match;
        if (clear) begin
            lst_d.vld = '0;
        end else if (wr_en) begin
            for (int i = 0; i < T; i++) begin
                if (wr_slot == CW'(i)) begin
                    lst_d.ent[i] = q_idx;
                    lst_d.vld[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lst_q <= '0;
        else        lst_q <= lst_d;
    end

    // A write always lands in a slot that is still empty this run.
    logic slot_busy;
    always_comb begin
        slot_busy = 1'b0;
        for (int i = 0; i < T; i++) begin
            if (wr_slot == CW'(i)) slot_busy = lst_q.vld[i];
        end
    end

    assert_slot_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |-> !slot_busy);

endmodule

// File: rtl/cwse_intake.sv
// Index handshake, region decode, memory read issue and run sequencing.
module cwse_intake
    import cwse_pkg::*;
#(
    parameter int M = 11,
    parameter int T = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            idx_valid,
    input  logic [M:0]      idx,
    output logic            idx_ready,
    output logic            col_rd_en,
    output logic [M:0]      col_addr,
    output logic            fold_en,
    output logic            tg_en,
    output logic [M:0]      tg_pos,
    output logic            done,
    output logic            err
);

    localparam int IW = M + 1;
    localparam int N  = 1 << M;
    localparam int R  = M * T;
    localparam int K  = N - R;
    localparam int CW = $clog2(T + 1);
    localparam logic [IW-1:0] K_IW = IW'(K);
    localparam logic [IW-1:0] N_IW = IW'(N);
    localparam logic [CW-1:0] LAST = CW'(T - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          err;
        logic          rd_pend;
        logic          tg_pend;
        logic [IW-1:0] tg_pos;
    } st_t;

    st_t  st_d, st_q;
    logic accept, in_q, out_rng, in_id, dup_hit;

    cwse_seen_list #(.T(T), .IW(IW), .CW(CW)) u_seen (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .wr_en   (accept),
        .wr_slot (st_q.cnt),
        .q_idx   (idx),
        .hit     (dup_hit)
    );

    assign idx_ready = (st_q.phase == PH_RUN) && !start;
    assign accept    = idx_valid && idx_ready;
    assign in_q      = idx < K_IW;
    assign out_rng   = idx >= N_IW;
    assign in_id     = !in_q && !out_rng;
    assign col_rd_en = accept && in_q;
    assign col_addr  = idx;

    always_comb begin
        st_d         = st_q;
        st_d.rd_pend = 1'b0;
        st_d.tg_pend = 1'b0;
        if (st_q.phase == PH_FLUSH) st_d.phase = PH_DONE;
        if (accept) begin
            st_d.cnt     = st_q.cnt + CW'(1);
            st_d.rd_pend = in_q;
            st_d.tg_pend = in_id;
            if (in_id) st_d.tg_pos = idx - K_IW;
            if (dup_hit || out_rng) st_d.err = 1'b1;
            if (st_q.cnt == LAST) st_d.phase = PH_FLUSH;
        end
        if (start) begin
            st_d       = '0;
            st_d.phase = PH_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fold_en = st_q.rd_pend;
    assign tg_en   = st_q.tg_pend;
    assign tg_pos  = st_q.tg_pos;
    assign done    = (st_q.phase == PH_DONE);
    assign err     = st_q.err;

    assert_start_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !idx_ready);

    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !idx_ready);

    assert_read_then_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_rd_en && !start) |=> (fold_en && !tg_en));

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FLUSH && !start) |=> done);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

endmodule

// File: rtl/cwse_accum.sv
// Syndrome register: column fold, single-bit toggle, clear.
module cwse_accum #(
    parameter int R  = 297,
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          fold_en,
    input  logic [R-1:0]  fold_col,
    input  logic          tg_en,
    input  logic [IW-1:0] tg_pos,
    output logic [R-1:0]  syn
);

    typedef struct packed {
        logic [R-1:0] acc;
    } acc_t;

    acc_t         ac_d, ac_q;
    logic [R-1:0] col_term, bit_term;

    always_comb begin
        col_term = fold_en ? fold_col : '0;
        bit_term = tg_en ? (R'(1) << tg_pos) : '0;
        ac_d     = ac_q;
        if (clear) ac_d.acc = '0;
        else       ac_d.acc = ac_q.acc ^ col_term ^ bit_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign syn = ac_q.acc;

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (syn == '0));

    assert_toggle_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tg_en && !fold_en && !clear) |=> ($countones(syn ^ $past(syn)) == 1));

endmodule

// File: rtl/cwse_syndrome_enc.sv
// Top: syndrome of a constant-weight error word against (Q | I).
module cwse_syndrome_enc #(
    parameter int M = 11,
    parameter int T = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             idx_valid,
    input  logic [M:0]       idx,
    output logic             idx_ready,
    output logic             col_rd_en,
    output logic [M:0]       col_addr,
    input  logic [M*T-1:0]   col_data,
    output logic [M*T-1:0]   syn,
    output logic             done,
    output logic             err
);

    localparam int IW = M + 1;
    localparam int R  = M * T;

    logic          fold_en, tg_en;
    logic [IW-1:0] tg_pos;

    cwse_intake #(.M(M), .T(T)) u_intake (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .idx_valid (idx_valid),
        .idx       (idx),
        .idx_ready (idx_ready),
        .col_rd_en (col_rd_en),
        .col_addr  (col_addr),
        .fold_en   (fold_en),
        .tg_en     (tg_en),
        .tg_pos    (tg_pos),
        .done      (done),
        .err       (err)
    );

    cwse_accum #(.R(R), .IW(IW)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .fold_en  (fold_en),
        .fold_col (col_data),
        .tg_en    (tg_en),
        .tg_pos   (tg_pos),
        .syn      (syn)
    );

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(syn)));

endmodule

// File: tb/test_cwse_syndrome_enc.sv
module test_cwse_syndrome_enc;

    localparam int M  = 5;
    localparam int T  = 3;
    localparam int N  = 1 << M;
    localparam int R  = M * T;
    localparam int K  = N - R;
    localparam int IW = M + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          idx_valid = 1'b0;
    logic [IW-1:0] idx = '0;
    logic          idx_ready, col_rd_en, done, err;
    logic [IW-1:0] col_addr;
    logic [R-1:0]  col_data = '0;
    logic [R-1:0]  syn;

    int checks = 0;
    int failures = 0;
    int rd_count = 0;
    int bad_addr = 0;
    int plist [T];
    logic [R-1:0] qmem [K];

    always #4 clk = ~clk;

    cwse_syndrome_enc #(.M(M), .T(T)) i_cwse_syndrome_enc (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_valid(idx_valid),
        .idx(idx), .idx_ready(idx_ready), .col_rd_en(col_rd_en),
        .col_addr(col_addr), .col_data(col_data), .syn(syn),
        .done(done), .err(err)
    );

    // Synchronous column memory model, one cycle latency.
    always @(posedge clk) begin
        if (col_rd_en) begin
            rd_count = rd_count + 1;
            if (int'(col_addr) < K) col_data <= qmem[int'(col_addr)];
            else bad_addr = bad_addr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial product of the full matrix (Q | I) with the error word.
    function automatic logic [R-1:0] ref_syn();
        logic [R-1:0] s = '0;
        for (int i = 0; i < T; i++) begin
            int j = plist[i];
            if (j < N) begin
                for (int r = 0; r < R; r++) begin
                    logic b;
                    b = (j < K) ? qmem[j][r] : ((r == j - K) ? 1'b1 : 1'b0);
                    s[r] = s[r] ^ b;
                end
            end
        end
        return s;
    endfunction

    function automatic bit ref_err();
        bit e = 0;
        for (int i = 0; i < T; i++) begin
            if (plist[i] >= N) e = 1;
            for (int k = 0; k < i; k++) if (plist[k] == plist[i]) e = 1;
        end
        return e;
    endfunction

    function automatic int ref_reads();
        int c = 0;
        for (int i = 0; i < T; i++) if (plist[i] < K) c++;
        return c;
    endfunction

    task automatic run_enc(input int gap);
        logic [R-1:0] exp_s;
        logic [R-1:0] held;
        int stalls = 0;
        exp_s = ref_syn();
        @(negedge clk);
        start = 1'b1;
        #1 chk(idx_ready == 1'b0, "R6 ready low during start", 64'(idx_ready), 0);
        @(negedge clk);
        start = 1'b0;
        rd_count = 0;
        bad_addr = 0;
        for (int i = 0; i < T; i++) begin
            for (int g = 0; g < gap; g++) begin
                idx_valid = 1'b0;
                @(negedge clk);
            end
            idx_valid = 1'b1;
            idx = IW'(plist[i]);
            #1;
            while (!idx_ready) begin
                stalls++;
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        idx_valid = 1'b0;
        chk(stalls == 0, "R4 no stall while collecting", 64'(stalls), 0);
        chk(done == 1'b0, "R5 done not yet one edge after last", 64'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R5 done two edges after last", 64'(done), 1);
        chk(syn == exp_s, "R1 syndrome matches reference", 64'(syn), 64'(exp_s));
        chk(err == ref_err(), "R7/R8 error flag", 64'(err), 64'(ref_err()));
        chk(rd_count == ref_reads(), "R2/R3 memory reads only for Q region",
            64'(rd_count), 64'(ref_reads()));
        chk(bad_addr == 0, "R2 read address inside Q", 64'(bad_addr), 0);
        held = syn;
        idx_valid = 1'b1;
        idx = IW'(plist[0] % K);
        #1 chk(idx_ready == 1'b0, "R9 ready low after T", 64'(idx_ready), 0);
        repeat (3) @(negedge clk);
        idx_valid = 1'b0;
        chk(syn == held && done, "R9 extra valid ignored, R5 done held",
            64'(syn), 64'(held));
    endtask

    task automatic pick_random();
        for (int i = 0; i < T; i++) begin
            bit fresh;
            do begin
                plist[i] = int'($urandom % N);
                fresh = 1;
                for (int k = 0; k < i; k++) if (plist[k] == plist[i]) fresh = 0;
            end while (!fresh);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20120911));
        for (int i = 0; i < K; i++) qmem[i] = R'({$urandom, $urandom});
        repeat (3) @(negedge clk);
        chk({done, err, idx_ready, col_rd_en} == 4'b0, "R10 reset outputs",
            64'({done, err, idx_ready, col_rd_en}), 0);
        chk(syn == '0, "R10 reset syndrome", 64'(syn), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 boundary: both edges of the Q region and first identity bit.
        plist = '{0, K - 1, K};       run_enc(0);
        // R3 identity only, includes last position.
        plist = '{K, N - 1, K + 4};   run_enc(0);
        // R2 Q region only, with gaps between indices.
        plist = '{0, 1, 2};           run_enc(2);
        // R7 repeated Q column.
        plist = '{5, 5, 20};          run_enc(0);
        // R7 repeated identity position: toggles cancel.
        plist = '{20, 20, 3};         run_enc(1);
        // R8 out-of-range index contributes nothing.
        plist = '{40, 3, K + 2};      run_enc(0);

        // R6: start lands in the cycle a fetched column is due to fold.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx_valid = 1'b1;
        idx = IW'(40);
        @(negedge clk);
        idx = IW'(2);
        @(negedge clk);
        idx_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(syn == '0, "R6 start discards in-flight fold", 64'(syn), 0);
        chk({done, err} == 2'b0, "R6 start clears done and err",
            64'({done, err}), 0);
        plist = '{7, 19, 2};
        run_enc(0);

        for (int n = 0; n < 20; n++) begin
            pick_random();
            run_enc(n % 3);
        end
        finish_run();
    end

endmodule